// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block moves stereo audio between a parallel sample interface and a serial link. It has one transmit path and one receive path. Five framing formats share one shifter: standard I2S, left-justified, right-justified, and two DSP-style formats in which a short sync pulse marks the start of a frame. The bit clock and the frame clock can each be driven by the port or taken from outside. The two roles are chosen independently. Either clock's polarity can be inverted on its own.

When the port drives the bit clock, it makes that clock from the system clock `clk`. The master clock is taken as `clk`/2, and the bit clock is that master clock divided by 1, 2, 4, 8 or 16. A frame lasts 32 or 64 bit clocks, and one frame carries one left and one right sample. When the port follows external clocks, each clock pin passes through a two-flop synchronizer, and its edges are found relative to `clk`. That `clk` must therefore run several times faster than the bit clock.

Transmit words are right-aligned in `tx_left` and `tx_right`, and the active sample sits in the low bits. Received words appear right-aligned in `rx_left` and `rx_right`. A one-cycle `rx_valid` marks each new pair. Configuration is meant to be static and is changed only while reset is held.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst_n` is low: `sdata_out`, `rx_valid`, `rx_left` and `rx_right` are 0; `bclk_out` equals `cfg_bclk_inv`; `frame_out` equals `cfg_frame_inv`.
- R2: As bit-clock master, each half period of `bclk_out` lasts 2^`cfg_div` cycles of `clk`, for `cfg_div` from 0 to 4.
- R3: One frame lasts 64 bit clocks when `cfg_ratio64`=1 and 32 when it is 0. The frame level seen after polarity correction depends on the format. For codes 0–2 it is low for the first half (left) and high for the second half (right). For codes 3–4 it is high for exactly one bit clock at frame start. As master it changes only together with a bit-clock edge.
- R4: Format code 0 (I2S): the MSB of each channel comes one bit clock after the frame level changes.
- R5: Format code 1 (left-justified): the MSB of each channel is driven on the same bit-clock edge on which the frame level changes.
- R6: Format code 2 (right-justified): each channel's LSB is the last bit before the next frame-level change. Its MSB therefore comes a sample-width number of bits earlier.
- R7: Format code 3 (DSP, late) puts the left MSB one bit clock after the sync pulse starts. Format code 4 (DSP, early) puts it in the bit of the sync pulse. In both formats the right sample follows the left sample's LSB directly.
- R8: `cfg_bclk_inv`=1 inverts the bit clock at both pins. Data then changes on the rising pin edge and is sampled on the falling one. `cfg_frame_inv`=1 inverts the frame level at both pins.
- R9: `cfg_width` codes 0/1/2/3 select 16/20/24/32-bit samples. Transmit bits above the width are ignored, and slots beyond the width are sent as 0. Received bits outside the width are ignored, and `rx_left`/`rx_right` bits above the width read 0.
- R10: With `cfg_bclk_master`=0 and `cfg_frame_master`=0 the port follows `bclk_in` and `frame_in`. It transmits and receives in the selected format. `rx_valid` is a single-cycle pulse issued after the right channel's last bit.
- R11: `sdata_out` changes only on the drive edge of the bit clock. `sdata_in` is sampled on the opposite edge.
- R12: With both clock roles as master and `sdata_in` tied to `sdata_out`, the received words equal the transmitted words masked to the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 3 | Format: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP late, 4 DSP early |
| cfg_width | input | 2 | Sample width code: 16/20/24/32 bits |
| cfg_ratio64 | input | 1 | 1: 64 bit clocks per frame, 0: 32 |
| cfg_div | input | 3 | Bit-clock divider exponent 0..4 |
| cfg_bclk_inv | input | 1 | Invert bit clock |
| cfg_frame_inv | input | 1 | Invert frame clock |
| cfg_bclk_master | input | 1 | 1: drive bit clock |
| cfg_frame_master | input | 1 | 1: drive frame clock |
| tx_left | input | 32 | Left transmit sample, right-aligned |
| tx_right | input | 32 | Right transmit sample, right-aligned |
| rx_left | output | 32 | Last received left sample |
| rx_right | output | 32 | Last received right sample |
| rx_valid | output | 1 | One-cycle pulse on a new received pair |
| bclk_in | input | 1 | External bit clock |
| frame_in | input | 1 | External frame clock |
| bclk_out | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Bit clock output enable |
| frame_out | output | 1 | Generated frame clock |
| frame_oe | output | 1 | Frame clock output enable |
| sdata_out | output | 1 | Serial transmit data |
| sdata_in | input | 1 | Serial receive data |

## Verification
The bench captures whole frames from the pins and compares every bit and frame level against a model written from the format rules. An off-by-one in the I2S or DSP-late delay would shift every bit by one slot and break the capture. A miscomputed right-justified lead would misplace the MSB, and so would a mixed-up early/late DSP pulse. Padding is driven as ones on receive and as ones above the width on transmit, so a design that did not mask the width would leak those ones into the words or onto the line. Slave runs use inverted polarities, where a design that sampled on the wrong edge or missed the frame start would receive garbage. Divider extremes catch a wrong half-period count.

// File: rtl/asp_pkg.sv
// Shared constants, types and the slot-position decoder of the audio serial port.
// Assumes the sample width never exceeds half the frame length.
package asp_pkg;
    localparam int MAX_W = 32;   // widest sample
    localparam int POS_W = 7;    // counts up to a 64-bit frame

    typedef enum logic [2:0] {
        FMT_I2S  = 3'd0,
        FMT_LJ   = 3'd1,
        FMT_RJ   = 3'd2,
        FMT_DSPL = 3'd3,
        FMT_DSPE = 3'd4
    } fmt_e;

    typedef struct packed {
        logic             valid;   // slot carries a sample bit
        logic             ch;      // 0 left, 1 right
        logic [POS_W-2:0] idx;     // bit number counted from the MSB
    } slot_pos_t;

    // Map a width code to a bit count.
    function automatic logic [POS_W-1:0] width_of(input logic [1:0] code);
        case (code)
            2'd0:    return POS_W'(16);
            2'd1:    return POS_W'(20);
            2'd2:    return POS_W'(24);
            default: return POS_W'(32);
        endcase
    endfunction

    // Where a frame position lands in the sample stream for a format.
    function automatic slot_pos_t decode_pos(input fmt_e f, input logic [POS_W-1:0] c,
                                             input logic [POS_W-1:0] ratio,
                                             input logic [POS_W-1:0] w);
        logic [POS_W-1:0] cc, half, o, pad, rel;
        slot_pos_t p;
        half = ratio >> 1;
        cc   = c;
        if (f == FMT_I2S || f == FMT_DSPL)
            cc = (c == '0) ? ratio - POS_W'(1) : c - POS_W'(1);
        p = '0;
        case (f)
            FMT_DSPL, FMT_DSPE: begin
                p.ch    = (cc >= w);
                o       = p.ch ? cc - w : cc;
                p.valid = (cc < (w << 1));
                p.idx   = o[POS_W-2:0];
            end
            FMT_RJ: begin
                p.ch    = (cc >= half);
                o       = p.ch ? cc - half : cc;
                pad     = half - w;
                rel     = o - pad;
                p.valid = (o >= pad);
                p.idx   = rel[POS_W-2:0];
            end
            default: begin
                p.ch    = (cc >= half);
                o       = p.ch ? cc - half : cc;
                p.valid = (o < w);
                p.idx   = o[POS_W-2:0];
            end
        endcase
        return p;
    endfunction
endpackage

// File: rtl/asp_sync.sv
// Multi-stage synchronizer for asynchronous pins.
// Assumes STAGES >= 2; each bit is synchronized independently.
module asp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/asp_bitclk.sv
// Bit-clock source: divides clk as master or edge-detects a synchronized
// external clock as slave. All levels are polarity-corrected.
// Master ticks fire one cycle before the level flips; slave ticks fire when
// the synchronized level has already flipped.
module asp_bitclk #(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       master,
    input  logic [2:0] div,
    input  logic       ext_lvl,
    output logic       lvl,
    output logic       fall_tick,
    output logic       rise_tick
);
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] term;
    logic             lvl_m;
    logic             ext_prev;
    logic             tick_m;

    assign term   = DIV_W'((32'd1 << div) - 32'd1);
    assign tick_m = master && (dcnt == term);

    // Half-period counter and generated level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dcnt  <= '0;
            lvl_m <= 1'b0;
        end else if (master) begin
            if (tick_m) begin
                dcnt  <= '0;
                lvl_m <= ~lvl_m;
            end else begin
                dcnt <= dcnt + DIV_W'(1);
            end
        end
    end

    // Previous synchronized external level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_lvl;
    end

    assign lvl       = master ? lvl_m : ext_lvl;
    assign fall_tick = master ? (tick_m & lvl_m)  : (~ext_lvl & ext_prev);
    assign rise_tick = master ? (tick_m & ~lvl_m) : (ext_lvl & ~ext_prev);
endmodule

// File: rtl/asp_frame_core.sv
// Frame counter, transmit serializer and receive deserializer.
// Drives on fall ticks, samples on rise ticks; as frame slave the counter is
// realigned to the external frame start.
module asp_frame_core
    import asp_pkg::*;
#(
    parameter int W = MAX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  fmt_e         fmt,
    input  logic [1:0]   width_code,
    input  logic         ratio64,
    input  logic         frame_master,
    input  logic         fall_tick,
    input  logic         rise_tick,
    input  logic         frame_ext,
    input  logic         sdin,
    input  logic [W-1:0] tx_left,
    input  logic [W-1:0] tx_right,
    output logic         frame_lvl,
    output logic         sdout,
    output logic [W-1:0] rx_left,
    output logic [W-1:0] rx_right,
    output logic         rx_valid
);
    localparam int SEL_W = $clog2(W);

    logic [POS_W-1:0] ratio, half, w, cnt, cnt_next, cnt_rx;
    logic [POS_W-1:0] sel_tx;
    logic             dsp, start_evt, fprev, load, tx_bit;
    logic [W-1:0]     sh_l, sh_r, cur_l, cur_r, word, rx_sh_l, rx_sh_r, rx_cur;
    slot_pos_t        pos_tx, pos_rx;

    assign ratio     = ratio64 ? POS_W'(64) : POS_W'(32);
    assign half      = ratio >> 1;
    assign w         = width_of(width_code);
    assign dsp       = (fmt == FMT_DSPL) || (fmt == FMT_DSPE);
    assign cnt_next  = (cnt >= ratio - POS_W'(1)) ? '0 : cnt + POS_W'(1);
    assign start_evt = !frame_master && (dsp ? (frame_ext & ~fprev) : (~frame_ext & fprev));
    assign cnt_rx    = start_evt ? '0 : cnt;
    assign pos_tx    = decode_pos(fmt, cnt_next, ratio, w);
    assign pos_rx    = decode_pos(fmt, cnt_rx, ratio, w);
    assign load      = pos_tx.valid && !pos_tx.ch && (pos_tx.idx == '0);
    assign cur_l     = load ? tx_left  : sh_l;
    assign cur_r     = load ? tx_right : sh_r;
    assign word      = pos_tx.ch ? cur_r : cur_l;
    assign sel_tx    = w - POS_W'(1) - {1'b0, pos_tx.idx};
    assign tx_bit    = pos_tx.valid & word[sel_tx[SEL_W-1:0]];
    assign rx_cur    = pos_rx.ch ? rx_sh_r : rx_sh_l;

    // Transmit side: advance the frame position and drive the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '1;
            sdout     <= 1'b0;
            frame_lvl <= 1'b0;
            sh_l      <= '0;
            sh_r      <= '0;
        end else if (fall_tick) begin
            cnt   <= cnt_next;
            sdout <= tx_bit;
            if (load) begin
                sh_l <= tx_left;
                sh_r <= tx_right;
            end
            if (frame_master)
                frame_lvl <= dsp ? (cnt_next == '0) : (cnt_next >= half);
        end else if (rise_tick && start_evt) begin
            cnt <= '0;
        end
    end

    // Receive side: track the frame level and shift in sample bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fprev    <= 1'b0;
            rx_sh_l  <= '0;
            rx_sh_r  <= '0;
            rx_left  <= '0;
            rx_right <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (rise_tick) begin
                fprev <= frame_ext;
                if (pos_rx.valid) begin
                    if (pos_rx.ch) rx_sh_r <= (pos_rx.idx == '0) ? W'(sdin) : {rx_cur[W-2:0], sdin};
                    else           rx_sh_l <= (pos_rx.idx == '0) ? W'(sdin) : {rx_cur[W-2:0], sdin};
                    if (pos_rx.ch && ({1'b0, pos_rx.idx} == w - POS_W'(1))) begin
                        rx_left  <= rx_sh_l;
                        rx_right <= {rx_sh_r[W-2:0], sdin};
                        rx_valid <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/audio_serial_port.sv
// Stereo audio serial port top: selects clock roles, applies polarity and
// ties the synchronizer, bit-clock source and frame core together.
// Assumes configuration only changes while rst_n is low.
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int W           = MAX_W,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   cfg_fmt,
    input  logic [1:0]   cfg_width,
    input  logic         cfg_ratio64,
    input  logic [2:0]   cfg_div,
    input  logic         cfg_bclk_inv,
    input  logic         cfg_frame_inv,
    input  logic         cfg_bclk_master,
    input  logic         cfg_frame_master,
    input  logic [W-1:0] tx_left,
    input  logic [W-1:0] tx_right,
    output logic [W-1:0] rx_left,
    output logic [W-1:0] rx_right,
    output logic         rx_valid,
    input  logic         bclk_in,
    input  logic         frame_in,
    output logic         bclk_out,
    output logic         bclk_oe,
    output logic         frame_out,
    output logic         frame_oe,
    output logic         sdata_out,
    input  logic         sdata_in
);
    logic [2:0] pins_q;
    logic       bclk_lvl, fall_tick, rise_tick, frame_lvl, sdin_sel;

    asp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sdata_in, frame_in, bclk_in}),
        .q(pins_q)
    );

    asp_bitclk #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n),
        .master(cfg_bclk_master),
        .div(cfg_div),
        .ext_lvl(pins_q[0] ^ cfg_bclk_inv),
        .lvl(bclk_lvl),
        .fall_tick(fall_tick),
        .rise_tick(rise_tick)
    );

    // Own bit clock: data is already aligned, sample the pin directly.
    assign sdin_sel = cfg_bclk_master ? sdata_in : pins_q[2];

    asp_frame_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .fmt(fmt_e'(cfg_fmt)),
        .width_code(cfg_width),
        .ratio64(cfg_ratio64),
        .frame_master(cfg_frame_master),
        .fall_tick(fall_tick),
        .rise_tick(rise_tick),
        .frame_ext(pins_q[1] ^ cfg_frame_inv),
        .sdin(sdin_sel),
        .tx_left(tx_left),
        .tx_right(tx_right),
        .frame_lvl(frame_lvl),
        .sdout(sdata_out),
        .rx_left(rx_left),
        .rx_right(rx_right),
        .rx_valid(rx_valid)
    );

    assign bclk_out  = bclk_lvl ^ cfg_bclk_inv;
    assign frame_out = frame_lvl ^ cfg_frame_inv;
    assign bclk_oe   = cfg_bclk_master;
    assign frame_oe  = cfg_frame_master;
endmodule

// File: rtl/asp_checker.sv
// Temporal checks on the audio serial port, attached by bind.
module asp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_width,
    input logic [2:0]  cfg_div,
    input logic        cfg_bclk_master,
    input logic        cfg_frame_master,
    input logic        bclk_out,
    input logic        frame_out,
    input logic        sdata_out,
    input logic        rx_valid,
    input logic [31:0] rx_left,
    input logic [31:0] rx_right
);
    logic [31:0] mask;
    assign mask = (cfg_width == 2'd0) ? 32'h0000_FFFF :
                  (cfg_width == 2'd1) ? 32'h000F_FFFF :
                  (cfg_width == 2'd2) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;

    // R2: with a divider above one, a bit-clock level holds at least two cycles
    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bclk_master && cfg_div != 3'd0 && !$stable(bclk_out)) |=> $stable(bclk_out));

    // R3: a generated frame clock moves only with the bit clock
    a_r3_frame_with_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bclk_master && cfg_frame_master && !$stable(frame_out)) |-> !$stable(bclk_out));

    // R11: transmit data moves only with the bit clock
    a_r11_data_with_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bclk_master && !$stable(sdata_out)) |-> !$stable(bclk_out));

    // R10: the received-pair strobe lasts one cycle
    a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: received words carry nothing above the sample width
    a_r9_rx_masked: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (((rx_left & ~mask) == 32'd0) && ((rx_right & ~mask) == 32'd0)));
endmodule

bind audio_serial_port asp_checker u_asp_checker (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_div(cfg_div),
    .cfg_bclk_master(cfg_bclk_master), .cfg_frame_master(cfg_frame_master),
    .bclk_out(bclk_out), .frame_out(frame_out), .sdata_out(sdata_out),
    .rx_valid(rx_valid), .rx_left(rx_left), .rx_right(rx_right)
);

// File: tb/audio_serial_port_test.sv
// Directed bench for the audio serial port.
module audio_serial_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_fmt = 3'd0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_ratio64 = 1'b1;
    logic [2:0]  cfg_div = 3'd1;
    logic        cfg_bclk_inv = 1'b0, cfg_frame_inv = 1'b0;
    logic        cfg_bclk_master = 1'b1, cfg_frame_master = 1'b1;
    logic [31:0] tx_left = '0, tx_right = '0;
    logic [31:0] rx_left, rx_right;
    logic        rx_valid, bclk_out, bclk_oe, frame_out, frame_oe, sdata_out;
    logic        bclk_in = 1'b0, frame_in = 1'b0, sd_drv = 1'b0, loopback = 1'b1;
    logic        sdata_in;
    int          checks = 0, errors = 0;

    assign sdata_in = loopback ? sdata_out : sd_drv;

    always #2 clk = ~clk;   // 250 MHz

    audio_serial_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_width(cfg_width),
        .cfg_ratio64(cfg_ratio64), .cfg_div(cfg_div), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_frame_inv(cfg_frame_inv), .cfg_bclk_master(cfg_bclk_master),
        .cfg_frame_master(cfg_frame_master), .tx_left(tx_left), .tx_right(tx_right),
        .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
        .bclk_in(bclk_in), .frame_in(frame_in), .bclk_out(bclk_out), .bclk_oe(bclk_oe),
        .frame_out(frame_out), .frame_oe(frame_oe), .sdata_out(sdata_out), .sdata_in(sdata_in)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wbits(input int code);
        return (code == 0) ? 16 : (code == 1) ? 20 : (code == 2) ? 24 : 32;
    endfunction

    function automatic logic [31:0] wmask(input int w);
        return (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    endfunction

    // Bit model from the format rules: {valid, bit} for frame position c.
    function automatic logic [1:0] model_bit(input int fmt, input int c, input int w,
                                             input int ratio, input logic [31:0] l,
                                             input logic [31:0] r);
        int half = ratio / 2;
        int k = (fmt == 0 || fmt == 3) ? (c + ratio - 1) % ratio : c;
        int idx;
        logic [31:0] wd;
        bit ok;
        if (fmt <= 1) begin
            wd = (k < half) ? l : r; idx = k % half; ok = idx < w;
        end else if (fmt == 2) begin
            wd = (k < half) ? l : r; idx = (k % half) - (half - w); ok = idx >= 0;
        end else begin
            wd = (k < w) ? l : r; idx = (k < w) ? k : k - w; ok = k < 2 * w;
        end
        if (!ok) return 2'b00;
        return {1'b1, wd[w - 1 - idx]};
    endfunction

    function automatic logic model_frame(input int fmt, input int c, input int ratio);
        return (fmt < 3) ? (c >= ratio / 2) : (c == 0);
    endfunction

    task automatic setup(input int fmt, input int wc, input bit r64, input int div,
                         input bit binv, input bit finv, input bit master);
        rst_n = 1'b0;
        cfg_fmt = 3'(fmt); cfg_width = 2'(wc); cfg_ratio64 = r64; cfg_div = 3'(div);
        cfg_bclk_inv = binv; cfg_frame_inv = finv;
        cfg_bclk_master = master; cfg_frame_master = master; loopback = master;
        bclk_in = binv; frame_in = finv ^ (fmt < 3); sd_drv = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset values
    task automatic t_reset;
        setup(0, 0, 1, 1, 1, 0, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdata_out == 1'b0 && rx_valid == 1'b0 && rx_left == 0 && rx_right == 0,
            "R1 outputs cleared", {sdata_out, rx_valid}, 0);
        chk(bclk_out == 1'b1, "R1 bclk idle level", bclk_out, 1);
        chk(frame_out == 1'b0, "R1 frame idle level", frame_out, 0);
    endtask

    // R2: half-period length in clk cycles
    task automatic t_divider(input int div);
        int n = 0;
        logic p;
        setup(1, 0, 1, div, 0, 0, 1);
        repeat (40) @(negedge clk);
        p = bclk_out;
        while (bclk_out == p) @(negedge clk);
        p = bclk_out;
        do begin @(negedge clk); n++; end while (bclk_out == p && n < 100);
        chk(n == (1 << div), "R2 bclk half period", n, 1 << div);
    endtask

    // R3-R9, R11, R12: capture a master frame from the pins and loop back
    task automatic t_master(input int fmt, input int wc, input bit r64, input int div,
                            input bit binv, input bit finv, input string req,
                            input logic [31:0] l, input logic [31:0] r);
        int ratio = r64 ? 64 : 32, w = wbits(wc), k = -1, bad = 0, guard = 0;
        logic bp, fp, b, f;
        logic [1:0] m;
        tx_left = l; tx_right = r;
        setup(fmt, wc, r64, div, binv, finv, 1);
        bp = binv; fp = (fmt < 3) ? 1'b0 : 1'b1;
        while (k <= ratio && guard < 20000) begin
            @(negedge clk); guard++;
            b = bclk_out ^ binv; f = frame_out ^ finv;
            if (b && !bp) begin
                if (k < 0 && ((fmt < 3) ? (fp && !f) : (f && !fp))) k = 0;
                if (k >= 0) begin
                    if (f != model_frame(fmt, k % ratio, ratio)) bad++;
                    m = model_bit(fmt, k % ratio, w, ratio, l, r);
                    if (k < ratio && sdata_out != (m[1] & m[0])) bad++;
                    k++;
                end
                fp = f;
            end
            bp = b;
        end
        chk(bad == 0 && k > ratio, {req, " serial frame"}, bad, 0);
        guard = 0;
        while (!rx_valid && guard < 20000) begin @(negedge clk); guard++; end
        chk(rx_left == (l & wmask(w)), "R12 loopback left", rx_left, l & wmask(w));
        chk(rx_right == (r & wmask(w)), "R12 loopback right", rx_right, r & wmask(w));
    endtask

    // R10, R9, R8: follow external clocks, drive and receive a pattern
    task automatic t_slave(input int fmt, input int wc, input bit binv, input bit finv,
                           input string req, input logic [31:0] l, input logic [31:0] r);
        int ratio = 64, w = wbits(wc), bad = 0;
        logic [1:0] m;
        tx_left = ~l; tx_right = ~r;
        setup(fmt, wc, 1, 0, binv, finv, 0);
        repeat (4) @(negedge clk);
        for (int fr = 0; fr < 5; fr++) begin
            for (int c = 0; c < ratio; c++) begin
                m = model_bit(fmt, c, w, ratio, l, r);
                bclk_in = binv; frame_in = finv ^ model_frame(fmt, c, ratio);
                sd_drv = m[1] ? m[0] : 1'b1;   // padding driven as ones
                repeat (6) @(negedge clk);
                m = model_bit(fmt, c, w, ratio, ~l, ~r);
                if (fr >= 2 && sdata_out != (m[1] & m[0])) bad++;
                bclk_in = ~binv;
                repeat (6) @(negedge clk);
            end
        end
        chk(bad == 0, {req, " slave transmit"}, bad, 0);
        chk(rx_left == (l & wmask(w)), {req, " R10 slave rx left"}, rx_left, l & wmask(w));
        chk(rx_right == (r & wmask(w)), {req, " R10 slave rx right"}, rx_right, r & wmask(w));
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_divider(0);
        t_divider(2);
        t_divider(4);
        t_master(0, 0, 0, 1, 0, 0, "R4 R3 I2S", 32'hFFFF_A5C3, 32'h0000_3C96);
        t_master(1, 2, 1, 0, 0, 0, "R5 R9 LJ", 32'hFF12_3456, 32'hAB65_4321);
        t_master(2, 1, 1, 1, 0, 0, "R6 R11 RJ", 32'hFFF8_1234, 32'h0007_ABCD);
        t_master(3, 0, 1, 1, 0, 0, "R7 DSP late", 32'h1234_8001, 32'h0000_7FFE);
        t_master(4, 3, 1, 2, 0, 0, "R7 DSP early", 32'h89AB_CDEF, 32'h1357_9BDF);
        t_master(0, 3, 1, 1, 1, 1, "R8 inverted I2S", 32'hC001_D00D, 32'h5A5A_0FF0);
        t_slave(0, 0, 0, 0, "R10 I2S", 32'h0000_B00F, 32'h0000_4E21);
        t_slave(1, 2, 1, 1, "R8 LJ", 32'h00A1_B2C3, 32'h005D_6E7F);
        t_slave(3, 1, 0, 0, "R9 DSP late", 32'h000C_3A5F, 32'h0003_C5A0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule